// File: doc/BRIEF.md
# Scrambled-SRAM Key and Error Register Block

This block holds the software-visible registers of a scrambled-memory controller. A 32-bit register port with a word index reaches a read-only status word, a control word that starts a key renewal, two lock words, an 8-bit macro attribute word, and a pair of error words. The memory datapath reports integrity errors through two event inputs and an address. The block keeps a sticky bit for each kind of error and the address of the latest event, and raises an interrupt while either sticky bit is set.

A renewal runs a four-phase request/acknowledge exchange with a key provider in its own slower clock domain. The request is a level that crosses through a two-flop synchronizer. The acknowledge comes back through another one. When the acknowledge arrives, the block captures the key, the nonce and the seed-quality flag presented with it. While no valid key is held, the key and nonce outputs toward the datapath stay at zero.

Register indices are 0 status, 1 control lock, 2 control, 3 attribute lock, 4 attribute, 5 error type and 6 error address. Reads are combinational on the index.

Top module: `sram_csr_top`

## Requirements
- R1: Status (index 0) reads bit 0 = OR of the two error-type bits, bit 1 = key valid, bit 2 = key came from a valid seed, other bits zero.
- R2: Error type (index 5) has bit 0 correctable and bit 1 uncorrectable. A bit sets on its event input and stays set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R3: When an error event and a write-1 clear of the same bit fall in one cycle, the bit stays set.
- R4: Error address (index 6) loads the byte address on the cycle of any error event and holds it otherwise.
- R5: irq is high exactly while either error-type bit is set.
- R6: Writing 1 to bit 0 of control (index 2) with the control lock open and no exchange pending starts one key exchange. Control always reads zero.
- R7: Starting an exchange clears key valid on the next cycle. While key valid is 0, scrKey and scrNonce are all zeros.
- R8: A renewal write while an exchange is pending has no effect, so only one exchange results.
- R9: On the acknowledge, the block captures keyIn, nonceIn and seedValidIn onto scrKey, scrNonce and status bit 2, and sets key valid.
- R10: keyReq is a level that stays high until the acknowledge is seen. It drops after the acknowledge, and a new request waits until the acknowledge is low again.
- R11: The locks (index 1 guards control, index 3 guards the attribute) read 1 after reset. Writing 1 to bit 0 clears a lock, writing 0 has no effect, and only reset sets it again.
- R12: The attribute word (index 4, bits 7:0) is writable and drives sramAttr. It ignores writes while its lock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Main active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| errCorrIn | input | 1 | Correctable error event |
| errUncorrIn | input | 1 | Uncorrectable error event |
| errAddrIn | input | 32 | Byte address of the error event |
| irq | output | 1 | Integrity error interrupt |
| sramAttr | output | 8 | Macro attribute value |
| scrKey | output | 128 | Scrambling key to datapath |
| scrNonce | output | 64 | Scrambling nonce to datapath |
| keyClk | input | 1 | Key provider clock |
| keyRstN | input | 1 | Key provider domain reset |
| keyReq | output | 1 | Key request level, key domain |
| keyAck | input | 1 | Key acknowledge level, key domain |
| keyIn | input | 128 | Key returned with acknowledge |
| nonceIn | input | 64 | Nonce returned with acknowledge |
| seedValidIn | input | 1 | Seed-quality flag returned with acknowledge |

## Verification
The assertions check on every cycle that a new error event always leaves its bit set and loads the address. They also check that the locks never rise again, that a frozen attribute never moves, that the key outputs are zero whenever the key is not valid, and that the request level holds until the acknowledge. Only the bench scenarios can show the end-to-end exchange across the two clock domains. That covers the number of exchanges produced by repeated renewal writes, the captured key values, and that a locked control word starts nothing.

// File: rtl/sram_csr_pkg.sv
package sram_csr_pkg;
  localparam int RegAw = 3;
  localparam int DataW = 32;
  localparam int AttrW = 8;

  localparam logic [RegAw-1:0] IdxStatus   = 3'd0;
  localparam logic [RegAw-1:0] IdxCtrlLock = 3'd1;
  localparam logic [RegAw-1:0] IdxCtrl     = 3'd2;
  localparam logic [RegAw-1:0] IdxCfgLock  = 3'd3;
  localparam logic [RegAw-1:0] IdxCfg      = 3'd4;
  localparam logic [RegAw-1:0] IdxErrType  = 3'd5;
  localparam logic [RegAw-1:0] IdxErrAddr  = 3'd6;

  typedef struct packed {
    logic clrCtrlLock;
    logic clrCfgLock;
    logic cfgWe;
    logic clrCorr;
    logic clrUncorr;
    logic keyLatch;
    logic validClr;
  } strobeT;
endpackage

// File: rtl/sram_csr_sync.sv
module sram_csr_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [Stages-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[Stages-2:0], d};
  end

  assign q = chain[Stages-1];
endmodule

// File: rtl/sram_csr_ctrl.sv
module sram_csr_ctrl
  import sram_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [RegAw-1:0] regAddr,
  input  logic [DataW-1:0] regWdata,
  input  logic             ctrlLock,
  input  logic             cfgLock,
  input  logic             ackSync,
  output logic             reqLvl,
  output strobeT           strobes
);
  logic ackPrev;
  logic ackRise;
  logic pending;
  logic renewHit;
  logic startReq;

  assign ackRise  = ackSync && !ackPrev;
  assign pending  = reqLvl || ackSync;
  assign renewHit = regWe && (regAddr == IdxCtrl) && regWdata[0] && ctrlLock;
  assign startReq = renewHit && !pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqLvl  <= 1'b0;
      ackPrev <= 1'b0;
    end else begin
      ackPrev <= ackSync;
      if (ackRise)       reqLvl <= 1'b0;
      else if (startReq) reqLvl <= 1'b1;
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.clrCtrlLock = regWe && (regAddr == IdxCtrlLock) && regWdata[0];
    strobes.clrCfgLock  = regWe && (regAddr == IdxCfgLock) && regWdata[0];
    strobes.cfgWe       = regWe && (regAddr == IdxCfg) && cfgLock;
    strobes.clrCorr     = regWe && (regAddr == IdxErrType) && regWdata[0];
    strobes.clrUncorr   = regWe && (regAddr == IdxErrType) && regWdata[1];
    strobes.keyLatch    = ackRise;
    strobes.validClr    = startReq;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqLvl && !ackSync |=> reqLvl); // R10
  AST_REQ_WAITS_ACK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ackSync |=> !$rose(reqLvl)); // R10
endmodule

// File: rtl/sram_csr_dp.sv
module sram_csr_dp
  import sram_csr_pkg::*;
#(
  parameter int KeyW   = 128,
  parameter int NonceW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [RegAw-1:0]  regAddr,
  input  logic [DataW-1:0]  regWdata,
  output logic [DataW-1:0]  regRdata,
  input  logic              errCorrIn,
  input  logic              errUncorrIn,
  input  logic [DataW-1:0]  errAddrIn,
  input  logic [KeyW-1:0]   keyIn,
  input  logic [NonceW-1:0] nonceIn,
  input  logic              seedValidIn,
  output logic              ctrlLock,
  output logic              cfgLock,
  output logic              irq,
  output logic [AttrW-1:0]  sramAttr,
  output logic [KeyW-1:0]   scrKey,
  output logic [NonceW-1:0] scrNonce
);
  logic [1:0]        errType;
  logic [DataW-1:0]  errAddr;
  logic [AttrW-1:0]  cfgAttr;
  logic              keyValid;
  logic              seedValid;
  logic [KeyW-1:0]   keyReg;
  logic [NonceW-1:0] nonceReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlLock <= 1'b1;
      cfgLock  <= 1'b1;
      cfgAttr  <= '0;
    end else begin
      if (strobes.clrCtrlLock) ctrlLock <= 1'b0;
      if (strobes.clrCfgLock)  cfgLock  <= 1'b0;
      if (strobes.cfgWe)       cfgAttr  <= regWdata[AttrW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errType <= '0;
      errAddr <= '0;
    end else begin
      errType[0] <= (errType[0] && !strobes.clrCorr) || errCorrIn;
      errType[1] <= (errType[1] && !strobes.clrUncorr) || errUncorrIn;
      if (errCorrIn || errUncorrIn) errAddr <= errAddrIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyValid  <= 1'b0;
      seedValid <= 1'b0;
      keyReg    <= '0;
      nonceReg  <= '0;
    end else if (strobes.keyLatch) begin
      keyValid  <= 1'b1;
      seedValid <= seedValidIn;
      keyReg    <= keyIn;
      nonceReg  <= nonceIn;
    end else if (strobes.validClr) begin
      keyValid  <= 1'b0;
      seedValid <= 1'b0;
      keyReg    <= '0;
      nonceReg  <= '0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      IdxStatus:   regRdata[2:0]       = {seedValid, keyValid, |errType};
      IdxCtrlLock: regRdata[0]         = ctrlLock;
      IdxCfgLock:  regRdata[0]         = cfgLock;
      IdxCfg:      regRdata[AttrW-1:0] = cfgAttr;
      IdxErrType:  regRdata[1:0]       = errType;
      IdxErrAddr:  regRdata            = errAddr;
      default:     regRdata            = '0;
    endcase
  end

  assign irq      = |errType;
  assign sramAttr = cfgAttr;
  assign scrKey   = keyReg;
  assign scrNonce = nonceReg;

  AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    errCorrIn |=> errType[0]); // R3
  AST_ERR_WINS_UNC: assert property (@(posedge clk) disable iff (!rstN)
    errUncorrIn |=> errType[1]); // R3
  AST_ERR_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (errCorrIn || errUncorrIn) |=> errAddr == $past(errAddrIn)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlLock |=> !ctrlLock); // R11
  AST_CFG_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLock |=> !cfgLock); // R11
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLock |=> $stable(cfgAttr)); // R12
  AST_KEY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid |-> (keyReg == '0 && nonceReg == '0)); // R7
endmodule

// File: rtl/sram_csr_top.sv
module sram_csr_top
  import sram_csr_pkg::*;
#(
  parameter int KeyW       = 128,
  parameter int NonceW     = 64,
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              errCorrIn,
  input  logic              errUncorrIn,
  input  logic [31:0]       errAddrIn,
  output logic              irq,
  output logic [7:0]        sramAttr,
  output logic [KeyW-1:0]   scrKey,
  output logic [NonceW-1:0] scrNonce,
  input  logic              keyClk,
  input  logic              keyRstN,
  output logic              keyReq,
  input  logic              keyAck,
  input  logic [KeyW-1:0]   keyIn,
  input  logic [NonceW-1:0] nonceIn,
  input  logic              seedValidIn
);
  strobeT strobes;
  logic   reqLvl;
  logic   ackSync;
  logic   ctrlLock;
  logic   cfgLock;

  sram_csr_sync #(.Stages(SyncStages)) uReqSync (
    .clk(keyClk), .rstN(keyRstN), .d(reqLvl), .q(keyReq)
  );

  sram_csr_sync #(.Stages(SyncStages)) uAckSync (
    .clk(clk), .rstN(rstN), .d(keyAck), .q(ackSync)
  );

  sram_csr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .ctrlLock(ctrlLock), .cfgLock(cfgLock),
    .ackSync(ackSync), .reqLvl(reqLvl), .strobes(strobes)
  );

  sram_csr_dp #(.KeyW(KeyW), .NonceW(NonceW)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .errCorrIn(errCorrIn),
    .errUncorrIn(errUncorrIn), .errAddrIn(errAddrIn), .keyIn(keyIn),
    .nonceIn(nonceIn), .seedValidIn(seedValidIn), .ctrlLock(ctrlLock),
    .cfgLock(cfgLock), .irq(irq), .sramAttr(sramAttr), .scrKey(scrKey),
    .scrNonce(scrNonce)
  );
endmodule

// File: tb/tb_sram_csr_top.sv
`timescale 1ns/1ps
module tb_sram_csr_top;
  localparam int KeyW = 128;
  localparam int NonceW = 64;
  localparam int RespDelay = 20;

  logic clk = 0, keyClk = 0, rstN = 0, keyRstN = 0;
  logic regWe = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic errCorrIn = 0, errUncorrIn = 0;
  logic [31:0] errAddrIn = 0;
  logic irq, keyReq;
  logic keyAck = 0, seedValidIn = 0;
  logic [7:0] sramAttr;
  logic [KeyW-1:0] scrKey, keyIn = 0;
  logic [NonceW-1:0] scrNonce, nonceIn = 0;

  int checks = 0, errors = 0, handshakes = 0;
  logic [KeyW-1:0] nextKey = 0;
  logic [NonceW-1:0] nextNonce = 0;
  logic nextSeed = 0;

  // reference state
  logic mCorr, mUnc, mCfgLock;
  logic [7:0] mCfg;

  always #2.5 clk = ~clk;
  always #6.5 keyClk = ~keyClk;

  sram_csr_top dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .errCorrIn(errCorrIn),
    .errUncorrIn(errUncorrIn), .errAddrIn(errAddrIn), .irq(irq),
    .sramAttr(sramAttr), .scrKey(scrKey), .scrNonce(scrNonce),
    .keyClk(keyClk), .keyRstN(keyRstN), .keyReq(keyReq), .keyAck(keyAck),
    .keyIn(keyIn), .nonceIn(nonceIn), .seedValidIn(seedValidIn)
  );

  task automatic chk(input string req, input logic [KeyW-1:0] act, input logic [KeyW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCorr = 0; mUnc = 0; mCfgLock = 1; mCfg = 0;
    end else begin
      if (regWe && regAddr == 3'd5) begin
        if (regWdata[0]) mCorr = 0;
        if (regWdata[1]) mUnc = 0;
      end
      if (errCorrIn) mCorr = 1;
      if (errUncorrIn) mUnc = 1;
      if (regWe && regAddr == 3'd4 && mCfgLock) mCfg = regWdata[7:0];
      if (regWe && regAddr == 3'd3 && regWdata[0]) mCfgLock = 0;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R5 irq per cycle", KeyW'(irq), KeyW'(mCorr | mUnc));
      chk("R12 sramAttr per cycle", KeyW'(sramAttr), KeyW'(mCfg));
    end
  end

  // key provider responder
  initial begin
    forever begin
      @(posedge keyClk);
      if (keyReq && !keyAck) begin
        repeat (RespDelay) @(posedge keyClk);
        keyIn = nextKey; nonceIn = nextNonce; seedValidIn = nextSeed;
        keyAck = 1;
        while (keyReq) @(posedge keyClk);
        keyAck = 0;
        handshakes++;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5 d = regRdata;
  endtask

  task automatic waitValid(output logic ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 600; i++) begin
      rd(3'd0, s);
      if (s[1]) begin ok = 1; break; end
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!keyReq && !keyAck) break;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic finishUp();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    logic [31:0] d;
    logic ok;
    int hs0;
    repeat (4) @(negedge clk);
    rstN = 1; keyRstN = 1;
    // reset state
    rd(3'd0, d); chk("R1 status after reset", KeyW'(d), 0);
    rd(3'd1, d); chk("R11 ctrl lock reset", KeyW'(d), 1);
    rd(3'd3, d); chk("R11 cfg lock reset", KeyW'(d), 1);
    chk("R7 key zero after reset", scrKey, 0);
    chk("R7 nonce zero after reset", KeyW'(scrNonce), 0);
    chk("R10 no request after reset", KeyW'(keyReq), 0);

    // correctable error
    @(negedge clk); errCorrIn = 1; errAddrIn = 32'h0000_1230;
    @(negedge clk); errCorrIn = 0;
    rd(3'd5, d); chk("R2 corr sets bit0", KeyW'(d), 1);
    rd(3'd6, d); chk("R4 error address", KeyW'(d), 32'h0000_1230);
    rd(3'd0, d); chk("R1 summary bit", KeyW'(d), 1);
    // uncorrectable error
    @(negedge clk); errUncorrIn = 1; errAddrIn = 32'h0000_4568;
    @(negedge clk); errUncorrIn = 0;
    rd(3'd5, d); chk("R2 both bits", KeyW'(d), 3);
    rd(3'd6, d); chk("R4 latest address", KeyW'(d), 32'h0000_4568);
    wr(3'd5, 0);
    rd(3'd5, d); chk("R2 write 0 keeps bits", KeyW'(d), 3);
    wr(3'd5, 1);
    rd(3'd5, d); chk("R2 clear corr only", KeyW'(d), 2);
    rd(3'd0, d); chk("R1 summary held by uncorr", KeyW'(d), 1);
    // same-cycle clear and new event
    @(negedge clk);
    regWe = 1; regAddr = 3'd5; regWdata = 2; errUncorrIn = 1; errAddrIn = 32'h0000_0abc;
    @(negedge clk); regWe = 0; errUncorrIn = 0;
    rd(3'd5, d); chk("R3 new error wins", KeyW'(d), 2);
    rd(3'd6, d); chk("R4 address on same-cycle event", KeyW'(d), 32'h0000_0abc);
    wr(3'd5, 3);
    rd(3'd0, d); chk("R1 summary drops", KeyW'(d), 0);
    chk("R5 irq low", KeyW'(irq), 0);

    // attribute and its lock
    wr(3'd4, 32'h0000_015a);
    rd(3'd4, d); chk("R12 attribute write", KeyW'(d), 32'h5a);
    wr(3'd3, 0);
    rd(3'd3, d); chk("R11 write 0 keeps lock", KeyW'(d), 1);
    wr(3'd3, 1);
    rd(3'd3, d); chk("R11 lock cleared", KeyW'(d), 0);
    wr(3'd4, 32'hff);
    rd(3'd4, d); chk("R12 frozen attribute", KeyW'(d), 32'h5a);
    wr(3'd3, 1);
    rd(3'd3, d); chk("R11 lock stays 0", KeyW'(d), 0);

    // first renewal, with a repeat write while pending
    nextKey = {4{32'hc0de_1234}}; nextNonce = {2{32'h5eed_9876}}; nextSeed = 1;
    hs0 = handshakes;
    wr(3'd2, 1);
    rd(3'd2, d); chk("R6 control reads zero", KeyW'(d), 0);
    repeat (12) @(negedge clk);
    chk("R10 request level raised", KeyW'(keyReq), 1);
    wr(3'd2, 1);
    waitValid(ok);
    chk("R9 key valid set", KeyW'(ok), 1);
    chk("R9 key captured", scrKey, nextKey);
    chk("R9 nonce captured", KeyW'(scrNonce), KeyW'(nextNonce));
    rd(3'd0, d); chk("R9 seed bit", KeyW'(d[2:1]), 3);
    waitIdle();
    chk("R10 request dropped", KeyW'(keyReq), 0);
    chk("R8 one exchange only", KeyW'(handshakes - hs0), 1);

    // renewal while valid clears valid
    nextKey = {4{32'h0badf00d}}; nextNonce = {2{32'h1357_2468}}; nextSeed = 0;
    wr(3'd2, 1);
    rd(3'd0, d); chk("R7 valid cleared", KeyW'(d[2:1]), 0);
    chk("R7 key zero while invalid", scrKey, 0);
    waitValid(ok);
    chk("R9 second key", scrKey, nextKey);
    rd(3'd0, d); chk("R9 unseeded key", KeyW'(d[2:1]), 1);
    waitIdle();

    // control lock blocks renewal
    hs0 = handshakes;
    wr(3'd1, 1);
    rd(3'd1, d); chk("R11 ctrl lock cleared", KeyW'(d), 0);
    wr(3'd2, 1);
    repeat (150) @(negedge clk);
    rd(3'd0, d); chk("R11 locked control ignored", KeyW'(d[1]), 1);
    chk("R6 no exchange when locked", KeyW'(handshakes - hs0), 0);
    chk("R10 no request when locked", KeyW'(keyReq), 0);
    finishUp();
  end
endmodule